// File: doc/BRIEF.md
# Three-Source Interrupt Controller

This block collects interrupt requests for a small 8-bit processor core. Three events can raise a request: a falling edge on an external pin, and single-cycle time-out pulses from two timers (timer A and timer B). Each event sets its own bit in a pending-flag register. The bit is set whether or not that source is enabled. Each flag is qualified by its bit in a mask register. The qualified flags are then gated by a global enable flag. The result is one request line to the core, which always carries the same vector address, 0x0008.

When the core takes the interrupt it pulses an acknowledge input. That clears the global enable, so no further request reaches the core while the handler runs. A return-from-interrupt pulse sets the global enable again. A separate wake output tells the power-down controller that an enabled external-pin request is pending. This output ignores the global enable. Software reaches both registers through a simple byte-wide register port: writes take effect on the clock edge, and the read data is combinational.

Top module: `tri_src_irq_ctrl`

## Requirements
- R1: After reset the mask register and the flag register both read 0x00, and irq_o and wake_o are low. The global enable is set.
- R2: The mask register is at address 0xC9. Bit 0 enables the pin source, bit 4 enables timer A and bit 5 enables timer B. Only these three bits store write data. Reads return them in place, and every other bit reads 0.
- R3: The flag register is at address 0xC8 and uses the same bit positions as the mask register. A timer pulse sets its flag (bit 4 for A, bit 5 for B) at the next clock edge, whatever the mask holds. Unused bits read 0.
- R4: The pin passes through a two-flop synchronizer. A high-to-low transition sampled at edge k sets flag bit 0 at edge k+2. A low-to-high transition sets nothing.
- R5: A flag bit clears only when 0 is written to that bit position. Writing 1 leaves it unchanged. If a set event and a clearing write land in the same cycle, the flag stays set.
- R6: irq_o is high exactly when the global enable is set and some flag bit has its mask bit set. Unmasking a source whose flag is already pending raises irq_o on the next cycle. vector_o is always 0x0008.
- R7: An acknowledge pulse clears the global enable, so irq_o is low in the following cycle. A return pulse sets the global enable. When both pulses arrive in the same cycle, the acknowledge wins.
- R8: wake_o is high exactly when flag bit 0 and mask bit 0 are both set, whatever the global enable holds. Timer flags never raise wake_o.
- R9: Reads from any address other than 0xC8 and 0xC9 return 0x00. Writes to such addresses change neither register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin_i | input | 1 | External interrupt pin, asynchronous |
| tmr_a_tout_i | input | 1 | Timer A time-out pulse |
| tmr_b_tout_i | input | 1 | Timer B time-out pulse |
| bus_addr_i | input | 8 | Register address |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for bus_addr_i |
| irq_ack_i | input | 1 | Core has taken the interrupt |
| irq_ret_i | input | 1 | Core executed return-from-interrupt |
| irq_o | output | 1 | Interrupt request to the core |
| vector_o | output | 16 | Fixed service vector address |
| wake_o | output | 1 | Wake request to the power-down controller |

## Verification
There are two same-cycle collisions.

The first is a software write that clears a flag arriving in the same cycle as a new event for that flag. The bench provokes it with a zero write to the flag register and a timer pulse in the same cycle. It passes if the flag reads back as set. The second is an acknowledge and a return pulse arriving together. It passes if the global enable ends up cleared, which shows as irq_o low with a request still pending.

A random phase then drives these overlaps many more times. A behavioural model checks every cycle.

// File: rtl/irq3_pkg.sv
package irq3_pkg;

    localparam int NSRC    = 3;
    localparam int SRC_EXT = 0;
    localparam int SRC_TA  = 1;
    localparam int SRC_TB  = 2;

    localparam int BIT_EXT = 0;
    localparam int BIT_TA  = 4;
    localparam int BIT_TB  = 5;

    typedef logic [NSRC-1:0] src_vec_t;

    typedef struct packed {
        src_vec_t mask;
        src_vec_t flag;
    } reg_state_t;

    function automatic logic [7:0] src_to_byte(src_vec_t v);
        logic [7:0] b;
        b          = '0;
        b[BIT_EXT] = v[SRC_EXT];
        b[BIT_TA]  = v[SRC_TA];
        b[BIT_TB]  = v[SRC_TB];
        return b;
    endfunction

    function automatic src_vec_t byte_to_src(logic [7:0] b);
        src_vec_t v;
        v[SRC_EXT] = b[BIT_EXT];
        v[SRC_TA]  = b[BIT_TA];
        v[SRC_TB]  = b[BIT_TB];
        return v;
    endfunction

endpackage

// File: rtl/irq3_edge_sync.sv
module irq3_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic fall_o
);
    localparam int LEN = STAGES + 1;

    logic [LEN-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[LEN-2:0], pin_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    // the last synchronized sample is low and the one before it was high
    assign fall_o = !sh_q[STAGES-1] && sh_q[STAGES];

    assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);

endmodule

// File: rtl/irq3_regs.sv
module irq3_regs
    import irq3_pkg::*;
#(
    parameter int              ADDR_W    = 8,
    parameter int              DATA_W    = 8,
    parameter logic [ADDR_W-1:0] MASK_ADDR = 8'hC9,
    parameter logic [ADDR_W-1:0] FLAG_ADDR = 8'hC8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  src_vec_t          set_i,
    output src_vec_t          mask_o,
    output src_vec_t          flag_o
);
    reg_state_t st_d, st_q;
    logic       hit_mask, hit_flag;
    src_vec_t   wr_bits;
    logic       unused_hi;

    assign hit_mask  = wr_i && (addr_i == MASK_ADDR);
    assign hit_flag  = wr_i && (addr_i == FLAG_ADDR);
    assign wr_bits   = byte_to_src(wdata_i[7:0]);
    assign unused_hi = ^wdata_i;

    always_comb begin
        st_d = st_q;
        if (hit_mask) st_d.mask = wr_bits;
        if (hit_flag) st_d.flag = st_q.flag & wr_bits;
        st_d.flag = st_d.flag | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i == MASK_ADDR)      rdata_o[7:0] = src_to_byte(st_q.mask);
        else if (addr_i == FLAG_ADDR) rdata_o[7:0] = src_to_byte(st_q.flag);
    end

    assign mask_o = st_q.mask;
    assign flag_o = st_q.flag;

    assert_tmr_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        set_i[SRC_TA] |=> st_q.flag[SRC_TA]);

    assert_clear_by_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.flag[SRC_TA]) |-> $past(wr_i && addr_i == FLAG_ADDR));

    assert_ext_from_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.flag[SRC_EXT]) |-> $past(set_i[SRC_EXT]));

endmodule

// File: rtl/irq3_gate.sv
module irq3_gate
    import irq3_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     ack_i,
    input  logic     ret_i,
    input  src_vec_t mask_i,
    input  src_vec_t flag_i,
    output logic     irq_o,
    output logic     wake_o
);
    logic gen_d, gen_q;

    always_comb begin
        gen_d = gen_q;
        if (ack_i)      gen_d = 1'b0;
        else if (ret_i) gen_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gen_q <= 1'b1;
        else        gen_q <= gen_d;
    end

    assign irq_o  = gen_q && |(mask_i & flag_i);
    assign wake_o = mask_i[SRC_EXT] && flag_i[SRC_EXT];

    assert_ack_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |=> !irq_o);

endmodule

// File: rtl/tri_src_irq_ctrl.sv
module tri_src_irq_ctrl
    import irq3_pkg::*;
#(
    parameter int                ADDR_W      = 8,
    parameter int                DATA_W      = 8,
    parameter logic [ADDR_W-1:0] MASK_ADDR   = 8'hC9,
    parameter logic [ADDR_W-1:0] FLAG_ADDR   = 8'hC8,
    parameter int                VEC_W       = 16,
    parameter logic [VEC_W-1:0]  VECTOR      = 16'h0008,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_pin_i,
    input  logic              tmr_a_tout_i,
    input  logic              tmr_b_tout_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_wr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    input  logic              irq_ack_i,
    input  logic              irq_ret_i,
    output logic              irq_o,
    output logic [VEC_W-1:0]  vector_o,
    output logic              wake_o
);
    logic     ext_fall;
    src_vec_t set_vec, mask_v, flag_v;

    irq3_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (ext_pin_i),
        .fall_o (ext_fall)
    );

    always_comb begin
        set_vec          = '0;
        set_vec[SRC_EXT] = ext_fall;
        set_vec[SRC_TA]  = tmr_a_tout_i;
        set_vec[SRC_TB]  = tmr_b_tout_i;
    end

    irq3_regs #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .MASK_ADDR (MASK_ADDR),
        .FLAG_ADDR (FLAG_ADDR)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (bus_wr_i),
        .addr_i  (bus_addr_i),
        .wdata_i (bus_wdata_i),
        .rdata_o (bus_rdata_o),
        .set_i   (set_vec),
        .mask_o  (mask_v),
        .flag_o  (flag_v)
    );

    irq3_gate u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .ack_i  (irq_ack_i),
        .ret_i  (irq_ret_i),
        .mask_i (mask_v),
        .flag_i (flag_v),
        .irq_o  (irq_o),
        .wake_o (wake_o)
    );

    assign vector_o = VECTOR;

    assert_wake_pin_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_o) |-> $past(ext_fall || (bus_wr_i && bus_addr_i == MASK_ADDR)));

endmodule

// File: tb/sim_tri_src_irq_ctrl.sv
module sim_tri_src_irq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] A_MASK = 8'hC9;
    localparam logic [7:0] A_FLAG = 8'hC8;
    localparam logic [7:0] IMPL   = 8'h31;

    logic        clk = 0, rst_n = 0;
    logic        pin = 1, ta = 0, tb = 0, wr = 0, ack = 0, ret = 0;
    logic [7:0]  addr = 8'hC9, wdata = 0, rdata;
    logic        irq, wake;
    logic [15:0] vec;

    int tests = 0, fails = 0;
    bit done = 0;

    logic [7:0] m_mask, m_flag;
    logic       m_gen;
    logic       hist[$];

    tri_src_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .ext_pin_i(pin), .tmr_a_tout_i(ta),
        .tmr_b_tout_i(tb), .bus_addr_i(addr), .bus_wr_i(wr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_ack_i(ack),
        .irq_ret_i(ret), .irq_o(irq), .vector_o(vec), .wake_o(wake)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference, updated on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_mask = 0; m_flag = 0; m_gen = 1;
            hist = '{1'b1, 1'b1, 1'b1};
        end else begin
            logic fell;
            logic [7:0] nf;
            fell = (hist[1] == 1'b0) && (hist[0] == 1'b1);
            hist.push_back(pin);
            void'(hist.pop_front());
            nf = m_flag;
            if (wr && addr == A_FLAG) nf = nf & wdata & IMPL;
            if (fell) nf[0] = 1'b1;
            if (ta)   nf[4] = 1'b1;
            if (tb)   nf[5] = 1'b1;
            if (wr && addr == A_MASK) m_mask = wdata & IMPL;
            m_flag = nf;
            if (ack)      m_gen = 0;
            else if (ret) m_gen = 1;
        end
    end

    // compare on every falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [7:0] er;
            er = (addr == A_MASK) ? m_mask : (addr == A_FLAG) ? m_flag : 8'h00;
            if (addr == A_MASK)      chk("R2 rdata", {8'h0, rdata}, {8'h0, er});
            else if (addr == A_FLAG) chk("R3 rdata", {8'h0, rdata}, {8'h0, er});
            else                     chk("R9 rdata", {8'h0, rdata}, {8'h0, er});
            chk("R6 irq", {15'h0, irq}, {15'h0, m_gen && ((m_flag & m_mask) != 0)});
            chk("R6 vector", vec, 16'h0008);
            chk("R8 wake", {15'h0, wake}, {15'h0, m_flag[0] & m_mask[0]});
        end
    end

    task automatic drive(logic w, logic [7:0] a, logic [7:0] d,
                         logic pa, logic pb, logic k, logic r);
        @(posedge clk); #1;
        wr = w; addr = a; wdata = d; ta = pa; tb = pb; ack = k; ret = r;
    endtask

    task automatic idle(int n, logic [7:0] a);
        for (int i = 0; i < n; i++) drive(0, a, 8'h00, 0, 0, 0, 0);
    endtask

    task automatic look(string tag, logic [7:0] a, logic [7:0] exp);
        idle(1, a);
        @(negedge clk);
        chk(tag, {8'h0, rdata}, {8'h0, exp});
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog expired");
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        chk("R1 mask", {8'h0, rdata}, 16'h0);
        chk("R1 irq", {15'h0, irq}, 16'h0);
        chk("R1 wake", {15'h0, wake}, 16'h0);
        look("R1 flag", A_FLAG, 8'h00);

        drive(1, A_MASK, 8'hFF, 0, 0, 0, 0);
        look("R2 mask readback", A_MASK, 8'h31);
        drive(1, A_MASK, 8'h00, 0, 0, 0, 0);
        drive(0, A_FLAG, 8'h00, 1, 0, 0, 0);
        look("R3 timer A flag while masked", A_FLAG, 8'h10);
        chk("R6 masked no irq", {15'h0, irq}, 16'h0);
        drive(1, A_MASK, 8'h10, 0, 0, 0, 0);
        idle(1, A_FLAG); @(negedge clk);
        chk("R6 late unmask raises irq", {15'h0, irq}, 16'h1);

        drive(0, A_FLAG, 8'h00, 0, 0, 1, 0);
        idle(1, A_FLAG); @(negedge clk);
        chk("R7 ack drops irq", {15'h0, irq}, 16'h0);
        drive(0, A_FLAG, 8'h00, 0, 0, 0, 1);
        idle(1, A_FLAG); @(negedge clk);
        chk("R7 return restores irq", {15'h0, irq}, 16'h1);
        drive(0, A_FLAG, 8'h00, 0, 0, 1, 1);
        idle(1, A_FLAG); @(negedge clk);
        chk("R7 ack beats return", {15'h0, irq}, 16'h0);
        drive(0, A_FLAG, 8'h00, 0, 0, 0, 1);

        drive(1, A_FLAG, 8'hFF, 0, 0, 0, 0);
        look("R5 write one keeps flag", A_FLAG, 8'h10);
        drive(1, A_FLAG, 8'h00, 1, 0, 0, 0);
        look("R5 set beats clear", A_FLAG, 8'h10);
        drive(1, A_FLAG, 8'h00, 0, 0, 0, 0);
        look("R5 write zero clears", A_FLAG, 8'h00);

        drive(1, A_MASK, 8'h01, 0, 0, 1, 0);
        pin = 0;
        idle(4, A_FLAG); @(negedge clk);
        chk("R4 falling edge flag", {8'h0, rdata}, 16'h01);
        chk("R8 wake without global enable", {15'h0, wake}, 16'h1);
        chk("R8 irq held off", {15'h0, irq}, 16'h0);
        drive(1, A_FLAG, 8'h00, 0, 0, 0, 1);
        pin = 1;
        look("R4 rising edge ignored", A_FLAG, 8'h00);
        idle(3, A_FLAG);
        look("R4 rising edge ignored later", A_FLAG, 8'h00);

        drive(1, A_MASK, 8'h20, 0, 1, 0, 0);
        idle(1, A_FLAG); @(negedge clk);
        chk("R8 timer B no wake", {15'h0, wake}, 16'h0);
        chk("R3 timer B flag", {8'h0, rdata}, 16'h20);

        drive(1, 8'h55, 8'hFF, 0, 0, 0, 0);
        look("R9 other address reads zero", 8'h55, 8'h00);
        look("R9 mask untouched", A_MASK, 8'h20);
        look("R9 flag untouched", A_FLAG, 8'h20);

        for (int i = 0; i < 400; i++) begin
            logic [7:0] ra;
            int sel;
            sel = $urandom_range(0, 2);
            ra = (sel == 0) ? A_MASK : (sel == 1) ? A_FLAG : 8'($urandom_range(0, 255));
            if ($urandom_range(0, 6) == 0) pin = ~pin;
            drive($urandom_range(0, 4) == 0, ra, 8'($urandom),
                  $urandom_range(0, 8) == 0, $urandom_range(0, 8) == 0,
                  $urandom_range(0, 9) == 0, $urandom_range(0, 7) == 0);
        end
        idle(3, A_FLAG);
        @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule